// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a 14-bit successive-approximation converter from a single master clock. It accepts a start from a hardware strobe (active low, acting on its falling edge) or from a one-cycle software convert pulse. It then walks an acquisition window and a fixed 21-clock conversion window. During the conversion it presents trial codes to an external comparator and resolves the result one bit per trial, most significant bit first.

A rising edge on the calibration input starts a calibration. The calibration algorithm itself is outside this block and is stood in for by a busy period of fixed length. One BUSY flag covers conversions and calibrations alike. When automatic power-down is enabled, the converter is marked powered down after each conversion. The next start then pays a power-up delay before acquisition begins.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy, pwr_dn, trial_valid, trial_code and result are all 0.
- R2: A falling edge on conv_n (sampled at the clock) while idle starts a frame. busy rises at that clock edge and stays high for ACQ_CLKS + CONV_CLKS clocks (2 + 21 = 23 by default).
- R3: A one-cycle high on sw_conv while idle starts the same frame as R2.
- R4: The result is straight binary. With a comparator that reports cmp_hi = 1 when the input is at or above the presented trial code, result equals the input code after the frame.
- R5: Trials run MSB first, one bit per clock. The first trial presents 0x2000. trial_valid is high only while busy, for exactly RES clocks per conversion.
- R6: result changes only on the clock edge at which busy falls at the end of a conversion. It holds its old value during the whole frame.
- R7: A rising edge on cal_in while idle holds busy high for CAL_CLKS clocks (40 by default) and leaves result unchanged. If a conversion start and a calibration rise arrive in the same cycle, the conversion wins.
- R8: Start requests (sw_conv, conv_n falls, cal_in rises) that arrive while busy is high are dropped and are not queued.
- R9: With auto_pd_en high, pwr_dn rises on the clock edge that ends a conversion. A start while pwr_dn is high adds PWRUP_CLKS clocks (5 by default) to the busy period, and pwr_dn clears when acquisition begins. With auto_pd_en low, pwr_dn does not rise.
- R10: Holding conv_n low after a frame does not start another frame; only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_n | input | 1 | Hardware convert strobe, falling edge starts |
| sw_conv | input | 1 | Software convert pulse |
| cal_in | input | 1 | Calibration request, rising edge starts |
| auto_pd_en | input | 1 | Enable power-down after each conversion |
| cmp_hi | input | 1 | Comparator: input at or above trial code |
| busy | output | 1 | Conversion or calibration in progress |
| pwr_dn | output | 1 | Converter is powered down |
| trial_valid | output | 1 | trial_code holds a live trial |
| trial_code | output | 14 | Trial DAC code for the comparator |
| result | output | 14 | Last conversion result, straight binary |

## Verification
A bench comparator model converts a swept set of input codes, stepping through the full 14-bit range and including zero and full scale. The sweep alternates between the hardware and software start sources, so a wrong bit order, a stuck trial bit or a mis-sourced start shows up as a wrong code. Each frame's busy length is counted. Power-up, calibration and start-while-busy sequences are told apart from a plain conversion by their different busy lengths and by whether result moves. The result is sampled on the last busy cycle and on the first idle cycle, which pins the update to the busy fall.

// File: rtl/sar_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PWRUP = 3'd1,
        ST_ACQ   = 3'd2,
        ST_CONV  = 3'd3,
        ST_CAL   = 3'd4
    } seq_state_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/sar_start_det.sv
// Start edge detection: falling edge of the hardware strobe and rising
// edge of the calibration input, each against last cycle's sampled level.
// Assumes: inputs are already synchronous to clk.
module sar_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_n,
    input  logic cal_in,
    output logic hw_fall,
    output logic cal_rise
);
    logic conv_q;
    logic cal_q;

    // Keep one cycle of history of both request pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b1;
            cal_q  <= 1'b0;
        end else begin
            conv_q <= conv_n;
            cal_q  <= cal_in;
        end
    end

    // Edge flags from current level versus history.
    always_comb begin
        hw_fall  = conv_q & ~conv_n;
        cal_rise = ~cal_q & cal_in;
    end
endmodule

// File: rtl/sar_frame_ctl.sv
// Frame controller: walks idle, optional power-up, acquisition, conversion
// and stubbed calibration phases; flags trial cycles and the final cycle.
// Assumes: every phase length parameter is at least 1 and
// SETUP_CLKS + RES <= CONV_CLKS.
module sar_frame_ctl
    import sar_seq_pkg::*;
#(
    parameter int RES        = 14,
    parameter int CONV_CLKS  = 21,
    parameter int ACQ_CLKS   = 2,
    parameter int CAL_CLKS   = 40,
    parameter int PWRUP_CLKS = 5,
    parameter int SETUP_CLKS = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv_req,
    input  logic                   cal_req,
    input  logic                   auto_pd_en,
    output logic                   busy,
    output logic                   pwr_dn,
    output logic                   acq_phase,
    output logic                   trial_valid,
    output logic [$clog2(RES)-1:0] trial_idx,
    output logic                   conv_last
);
    localparam int MAXC  = max_of4(CONV_CLKS, ACQ_CLKS, CAL_CLKS, PWRUP_CLKS);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int IDX_W = $clog2(RES);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Phase sequencing and power-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            pwr_dn <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (conv_req)     state <= pwr_dn ? ST_PWRUP : ST_ACQ;
                    else if (cal_req) state <= ST_CAL;
                end
                ST_PWRUP: begin
                    if (cnt == CNT_W'(PWRUP_CLKS - 1)) begin
                        state  <= ST_ACQ;
                        cnt    <= '0;
                        pwr_dn <= 1'b0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_ACQ: begin
                    if (cnt == CNT_W'(ACQ_CLKS - 1)) begin
                        state <= ST_CONV;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_CONV: begin
                    if (cnt == CNT_W'(CONV_CLKS - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                        if (auto_pd_en) pwr_dn <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                ST_CAL: begin
                    if (cnt == CNT_W'(CAL_CLKS - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode phase flags and the current trial bit index.
    always_comb begin
        int off;
        busy        = (state != ST_IDLE);
        acq_phase   = (state == ST_ACQ);
        trial_valid = (state == ST_CONV) && (int'(cnt) >= SETUP_CLKS)
                      && (int'(cnt) < SETUP_CLKS + RES);
        off         = int'(cnt) - SETUP_CLKS;
        trial_idx   = trial_valid ? IDX_W'(RES - 1 - off) : '0;
        conv_last   = (state == ST_CONV) && (cnt == CNT_W'(CONV_CLKS - 1));
    end
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation datapath: holds resolved bits, forms the trial
// code, keeps or drops each trial bit from the comparator, loads result.
// Assumes: trials run from bit RES-1 downward, one per clock.
module sar_approx #(
    parameter int RES = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   trial_valid,
    input  logic [$clog2(RES)-1:0] trial_idx,
    input  logic                   cmp_hi,
    input  logic                   load,
    output logic [RES-1:0]         trial_code,
    output logic [RES-1:0]         result
);
    logic [RES-1:0] sar_q;
    logic [RES-1:0] bit_mask;

    // One-hot mask of the bit under trial.
    always_comb begin
        bit_mask   = trial_valid ? (RES'(1) << trial_idx) : '0;
        trial_code = trial_valid ? (sar_q | bit_mask) : '0;
    end

    // Approximation register: cleared in acquisition, one decision per trial.
    always_ff @(posedge clk) begin
        if (!rst_n)           sar_q <= '0;
        else if (clear)       sar_q <= '0;
        else if (trial_valid) sar_q <= cmp_hi ? (sar_q | bit_mask) : (sar_q & ~bit_mask);
    end

    // Result register: loaded on the final conversion clock only.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (load) result <= sar_q;
    end
endmodule

// File: rtl/sar_conv_seq.sv
// Top of the conversion sequencer: start detection, frame control and the
// approximation datapath. Starts are accepted only while idle.
// Assumes: all inputs synchronous to clk; calibration is a timed stub.
module sar_conv_seq #(
    parameter int RES        = 14,
    parameter int CONV_CLKS  = 21,
    parameter int ACQ_CLKS   = 2,
    parameter int CAL_CLKS   = 40,
    parameter int PWRUP_CLKS = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_n,
    input  logic           sw_conv,
    input  logic           cal_in,
    input  logic           auto_pd_en,
    input  logic           cmp_hi,
    output logic           busy,
    output logic           pwr_dn,
    output logic           trial_valid,
    output logic [RES-1:0] trial_code,
    output logic [RES-1:0] result
);
    localparam int IDX_W = $clog2(RES);

    logic             hw_fall;
    logic             cal_rise;
    logic             conv_req;
    logic             acq_phase;
    logic             conv_last;
    logic [IDX_W-1:0] trial_idx;

    sar_start_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .conv_n  (conv_n),
        .cal_in  (cal_in),
        .hw_fall (hw_fall),
        .cal_rise(cal_rise)
    );

    // Either start source requests a conversion.
    always_comb conv_req = hw_fall | sw_conv;

    sar_frame_ctl #(
        .RES       (RES),
        .CONV_CLKS (CONV_CLKS),
        .ACQ_CLKS  (ACQ_CLKS),
        .CAL_CLKS  (CAL_CLKS),
        .PWRUP_CLKS(PWRUP_CLKS),
        .SETUP_CLKS(1)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_req   (conv_req),
        .cal_req    (cal_rise),
        .auto_pd_en (auto_pd_en),
        .busy       (busy),
        .pwr_dn     (pwr_dn),
        .acq_phase  (acq_phase),
        .trial_valid(trial_valid),
        .trial_idx  (trial_idx),
        .conv_last  (conv_last)
    );

    sar_approx #(.RES(RES)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (acq_phase),
        .trial_valid(trial_valid),
        .trial_idx  (trial_idx),
        .cmp_hi     (cmp_hi),
        .load       (conv_last),
        .trial_code (trial_code),
        .result     (result)
    );
endmodule

// File: rtl/sar_conv_seq_chk.sv
// Property checker for the conversion sequencer, bound to the top module.
// Assumes: synchronous active-low reset asserted from time zero.
module sar_conv_seq_chk #(
    parameter int RES = 14
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           pwr_dn,
    input logic           trial_valid,
    input logic [RES-1:0] result
);
    // R5: trials happen only inside a busy frame.
    a_r5_trial_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        trial_valid |-> busy);

    // R6: result holds unless busy is falling.
    a_r6_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));

    // R9: power-down is entered only as a frame ends.
    a_r9_pd_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dn) |-> $fell(busy));

    // R9: power-down is left only inside a frame.
    a_r9_pd_leaves_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_dn) |-> busy);

    // R2: a frame lasts more than one clock.
    a_r2_busy_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES(RES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .pwr_dn     (pwr_dn),
    .trial_valid(trial_valid),
    .result     (result)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
    localparam int RES = 14, CONV = 21, ACQ = 2, CAL = 40, PWRUP = 5;
    localparam int FRAME = ACQ + CONV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_n = 1'b1, sw_conv = 1'b0, cal_in = 1'b0, auto_pd_en = 1'b0;
    logic cmp_hi;
    logic busy, pwr_dn, trial_valid;
    logic [RES-1:0] trial_code, result;
    logic [RES-1:0] vin = '0;
    logic [RES-1:0] last_res = '0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Bench comparator model.
    assign cmp_hi = (vin >= trial_code);

    sar_conv_seq #(.RES(RES), .CONV_CLKS(CONV), .ACQ_CLKS(ACQ),
                   .CAL_CLKS(CAL), .PWRUP_CLKS(PWRUP)) dut (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .sw_conv(sw_conv),
        .cal_in(cal_in), .auto_pd_en(auto_pd_en), .cmp_hi(cmp_hi),
        .busy(busy), .pwr_dn(pwr_dn), .trial_valid(trial_valid),
        .trial_code(trial_code), .result(result));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one frame: src 0 = hw strobe, 1 = sw pulse, 2 = calibration.
    // Returns the busy length; checks trials and result timing.
    task automatic run_frame(input int src, input int exp_len, input bit is_conv);
        int len, ntr, first_code;
        len = 0; ntr = 0; first_code = -1;
        if (src == 0) conv_n = 1'b0;
        else if (src == 1) sw_conv = 1'b1;
        else cal_in = 1'b1;
        @(negedge clk);
        conv_n = 1'b1; sw_conv = 1'b0;
        while (busy && len < 1000) begin
            len++;
            if (trial_valid) begin
                if (first_code < 0) first_code = int'(trial_code);
                ntr++;
            end
            if (!busy) break;
            @(negedge clk);
            // R6: result still old on every busy cycle
            if (busy) check("R6 hold", int'(result), int'(last_res));
        end
        check(src == 2 ? "R7 cal len" : (src == 0 ? "R2 len" : "R3 len"), len, exp_len);
        if (is_conv) begin
            check("R5 trials", ntr, RES);
            check("R5 first trial", first_code, 1 << (RES - 1));
            check("R4 result", int'(result), int'(vin));
            last_res = result;
        end else begin
            check("R7 result kept", int'(result), int'(last_res));
        end
        cal_in = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 pwr_dn", int'(pwr_dn), 0);
        check("R1 trial_valid", int'(trial_valid), 0);
        check("R1 trial_code", int'(trial_code), 0);
        check("R1 result", int'(result), 0);

        // R2/R3/R4 sweep across the code range, alternating sources
        for (int v = 0; v < (1 << RES); v += 61) begin
            vin = RES'(v);
            run_frame(v % 2, FRAME, 1'b1);
        end
        vin = '1;
        run_frame(0, FRAME, 1'b1);
        vin = '0;
        run_frame(1, FRAME, 1'b1);

        // R7 calibration
        run_frame(2, CAL, 1'b0);
        @(negedge clk);

        // R8 starts during busy are dropped
        vin = RES'(12345);
        sw_conv = 1'b1;
        @(negedge clk);
        sw_conv = 1'b0;
        repeat (5) @(negedge clk);
        sw_conv = 1'b1; conv_n = 1'b0; cal_in = 1'b1;
        @(negedge clk);
        sw_conv = 1'b0; conv_n = 1'b1;
        repeat (30) @(negedge clk);
        check("R8 no queued start", int'(busy), 0);
        check("R8 result", int'(result), 12345);
        last_res = result;
        cal_in = 1'b0;
        @(negedge clk);

        // R10 strobe held low does not retrigger
        vin = RES'(777);
        conv_n = 1'b0;
        @(negedge clk);
        repeat (FRAME + 10) @(negedge clk);
        check("R10 no retrigger", int'(busy), 0);
        check("R10 result", int'(result), 777);
        last_res = result;
        conv_n = 1'b1;
        @(negedge clk);

        // R9 automatic power-down
        auto_pd_en = 1'b1;
        vin = RES'(4096);
        run_frame(1, FRAME, 1'b1);
        check("R9 pd set", int'(pwr_dn), 1);
        vin = RES'(8191);
        run_frame(0, FRAME + PWRUP, 1'b1);
        check("R9 pd again", int'(pwr_dn), 1);
        auto_pd_en = 1'b0;
        vin = RES'(3);
        run_frame(1, FRAME + PWRUP, 1'b1);
        check("R9 pd cleared", int'(pwr_dn), 0);
        run_frame(1, FRAME, 1'b1);
        check("R9 pd stays low", int'(pwr_dn), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule